// File: doc/BRIEF.md
# Clock Source Transition Sequencer

This controller moves the processor clock between three sources: the on-chip high-speed oscillator, an external high-speed clock and a low-speed secondary oscillator. A request names the target source. The sequencer then runs a fixed, path-specific list of steps. It first enables or checks the target oscillator. It then waits until that oscillator is ready or its programmed settling count has elapsed. Finally it flips the source-select bits one per cycle, in an order that keeps the processor on a running clock at every moment.

The select and control bits are driven as register-style outputs, so the clock-mux logic can use them directly. A busy flag covers the whole sequence. A one-cycle done pulse marks the end of every accepted request, whether it completed or was aborted. An error flag reports a ready signal that never arrived. Requests are ignored while a sequence runs. A request for the source already in use finishes at once.

Top module: `clksrc_seq`

## Requirements
- R1: After reset, `cur_src` is 0 (source codes: 0 on-chip high-speed, 1 external high-speed, 2 secondary). `int_stop`, `main_sel`, `sub_osc_en`, `cpu_sub_sel`, `busy`, `done` and `err` are all 0.
- R2: A request for the current source gives `done` for exactly one cycle, in the cycle after the request. `busy` stays low and no control bit changes.
- R3: Toward the on-chip source from the external source, `int_stop` is cleared at acceptance. The sequencer waits for `int_osc_ok`. `main_sel` is cleared 3 cycles after the request and `done` follows 1 cycle later.
- R4: Toward the on-chip source from the secondary source, `int_stop` is cleared and the sequencer waits for `int_osc_ok`. It then clears `main_sel` and, one cycle later, clears `cpu_sub_sel`. When `ext_sel_cfg` is 0, the `main_sel` step is skipped and `cpu_sub_sel` is cleared 3 cycles after the request.
- R5: Toward the secondary source, `sub_osc_en` is set at acceptance and a down-counter is loaded from `stab_count` = N. `cpu_sub_sel` is set N+3 cycles after the request and `done` follows 1 cycle later.
- R6: Toward the external source, the sequencer waits for `ext_osc_ok` and then sets `main_sel` 3 cycles after the request. Coming from the secondary source, it then clears `cpu_sub_sel` one cycle later.
- R7: While `busy` is high, a new request is ignored and does not change the target reached.
- R8: If a ready input stays low for TMO_CYC cycles of waiting, the sequence aborts. `err` and `done` rise TMO_CYC+1 cycles after the request, and `main_sel`, `cpu_sub_sel` and `cur_src` keep their values. `err` clears when the next request is accepted.
- R9: `stop_int_req` sets `int_stop` only while idle with `cur_src` not 0. In any other case it has no effect.
- R10: A request with target code 3 is ignored: no `busy`, no `done`, no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transition request strobe |
| req_target | input | 2 | Target source code |
| ext_sel_cfg | input | 1 | External-select configuration bit |
| stab_count | input | CNT_W | Secondary oscillator settling count |
| stop_int_req | input | 1 | Request to stop the on-chip oscillator |
| int_osc_ok | input | 1 | On-chip oscillator running |
| ext_osc_ok | input | 1 | External clock present |
| int_stop | output | 1 | On-chip oscillator stop bit |
| int_stat | output | 1 | On-chip oscillator status bit |
| main_sel | output | 1 | Main clock select (1 = external) |
| sub_osc_en | output | 1 | Secondary oscillator enable |
| cpu_sub_sel | output | 1 | Processor clock select (1 = secondary) |
| cur_src | output | 2 | Source currently driving the processor |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence aborted on timeout |

## Verification
A wrong state register shows at the ports as a select bit that flips in the wrong cycle or out of order. Such a fault is visible within a few cycles of the request, or N+3 cycles after it on the secondary path. A corrupt counter moves the `cpu_sub_sel` edge away from N+3, so sweeping N exposes it at once. A wrong source record shows as a missing skip or a wrong step on the very next request, and often as `cur_src` disagreeing with the select bits.

// File: rtl/clksrc_seq.sv
module clksrc_seq #(
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_target,
  input  logic             ext_sel_cfg,
  input  logic [CNT_W-1:0] stab_count,
  input  logic             stop_int_req,
  input  logic             int_osc_ok,
  input  logic             ext_osc_ok,
  output logic             int_stop,
  output logic             int_stat,
  output logic             main_sel,
  output logic             sub_osc_en,
  output logic             cpu_sub_sel,
  output logic [1:0]       cur_src,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int TMO_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [1:0] SRC_INT = 2'd0, SRC_EXT = 2'd1, SRC_SUB = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_INT_WAIT, S_EXT_WAIT, S_SUB_WAIT, S_MAIN, S_CSS, S_FIN} st_t;

  st_t              st;
  logic [1:0]       src_q, tgt_q;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;
  logic             tmo_hit;

  assign busy     = (st != S_IDLE);
  assign int_stat = int_osc_ok;
  assign tmo_hit  = (tmo == TMO_W'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      src_q       <= SRC_INT;
      tgt_q       <= SRC_INT;
      cnt         <= '0;
      tmo         <= '0;
      cur_src     <= SRC_INT;
      int_stop    <= 1'b0;
      main_sel    <= 1'b0;
      sub_osc_en  <= 1'b0;
      cpu_sub_sel <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (stop_int_req && cur_src != SRC_INT) int_stop <= 1'b1;
          if (req_valid && req_target != 2'd3) begin
            err <= 1'b0;
            if (req_target == cur_src) begin
              done <= 1'b1;
            end else begin
              src_q <= cur_src;
              tgt_q <= req_target;
              tmo   <= '0;
              case (req_target)
                SRC_INT: begin int_stop <= 1'b0; st <= S_INT_WAIT; end
                SRC_EXT: st <= S_EXT_WAIT;
                default: begin sub_osc_en <= 1'b1; cnt <= stab_count; st <= S_SUB_WAIT; end
              endcase
            end
          end
        end
        S_INT_WAIT, S_EXT_WAIT: begin
          if ((st == S_INT_WAIT) ? int_osc_ok : ext_osc_ok) begin
            if (st == S_INT_WAIT && src_q == SRC_SUB && !ext_sel_cfg) st <= S_CSS;
            else st <= S_MAIN;
          end else if (tmo_hit) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        S_SUB_WAIT: begin
          if (cnt == '0) st <= S_CSS;
          else cnt <= cnt - 1'b1;
        end
        S_MAIN: begin
          main_sel <= (tgt_q == SRC_EXT);
          st <= (src_q == SRC_SUB) ? S_CSS : S_FIN;
        end
        S_CSS: begin
          cpu_sub_sel <= (tgt_q == SRC_SUB);
          st <= S_FIN;
        end
        S_FIN: begin
          cur_src <= tgt_q;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clksrc_seq_chk.sv
module clksrc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_stop,
  input logic       main_sel,
  input logic       sub_osc_en,
  input logic       cpu_sub_sel,
  input logic [1:0] cur_src,
  input logic       busy,
  input logic       done,
  input logic       err
);
  a_r2_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_select_moves_only_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(main_sel) && $stable(cpu_sub_sel)));
  a_r8_abort_keeps_selects: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($stable(main_sel) && $stable(cpu_sub_sel) && $stable(cur_src)));
  a_r3_main_clear_with_int_running: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_sel) |-> !int_stop);
  a_r5_sub_select_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_sub_sel) |-> sub_osc_en);
  a_r9_stop_only_off_int: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stop) |-> (cur_src != 2'd0));
endmodule

bind clksrc_seq clksrc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_stop(int_stop), .main_sel(main_sel),
  .sub_osc_en(sub_osc_en), .cpu_sub_sel(cpu_sub_sel), .cur_src(cur_src),
  .busy(busy), .done(done), .err(err)
);

// File: tb/sim_clksrc_seq.sv
module sim_clksrc_seq;
  localparam int TMO = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ext_sel_cfg = 1'b1, stop_int_req = 1'b0;
  logic int_osc_ok = 1'b1, ext_osc_ok = 1'b1;
  logic [1:0] req_target = '0;
  logic [7:0] stab_count = '0;
  logic int_stop, int_stat, main_sel, sub_osc_en, cpu_sub_sel, busy, done, err;
  logic [1:0] cur_src;
  int checks = 0, fails = 0, cyc = 0;
  int c_stop, c_main, c_css, c_done, busy_seen;

  clksrc_seq #(.CNT_W(8), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .ext_sel_cfg(ext_sel_cfg), .stab_count(stab_count), .stop_int_req(stop_int_req),
    .int_osc_ok(int_osc_ok), .ext_osc_ok(ext_osc_ok), .int_stop(int_stop),
    .int_stat(int_stat), .main_sel(main_sel), .sub_osc_en(sub_osc_en),
    .cpu_sub_sel(cpu_sub_sel), .cur_src(cur_src), .busy(busy), .done(done), .err(err));

  always #10 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [1:0] tgt, input int limit);
    logic ps, pm, pc;
    ps = int_stop; pm = main_sel; pc = cpu_sub_sel;
    c_stop = 0; c_main = 0; c_css = 0; c_done = 0; busy_seen = 0;
    req_valid = 1'b1; req_target = tgt;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (busy) busy_seen = 1;
      if (int_stop != ps && c_stop == 0) c_stop = c;
      if (main_sel != pm && c_main == 0) c_main = c;
      if (cpu_sub_sel != pc && c_css == 0) c_css = c;
      ps = int_stop; pm = main_sel; pc = cpu_sub_sel;
      if (done && c_done == 0) c_done = c;
      if (c_done != 0) break;
    end
  endtask

  task automatic stop_pulse;
    stop_int_req = 1'b1;
    @(negedge clk);
    stop_int_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int em;
    repeat (2) @(negedge clk);
    chk("R1 cur_src", cur_src, 0);
    chk("R1 selects", {int_stop, main_sel, sub_osc_en, cpu_sub_sel}, 0);
    chk("R1 flags", {busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(2'd0, 10);
    chk("R2 done cycle", c_done, 1);
    chk("R2 busy", busy_seen, 0);
    @(negedge clk);
    chk("R2 done width", done, 0);

    stop_pulse();
    chk("R9 stop ignored on int", int_stop, 0);
    req_valid = 1'b1; req_target = 2'd3;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 no busy/done", {busy, done}, 0);
    end
    chk("R10 source kept", cur_src, 0);

    for (int n = 0; n < 6; n++) begin
      for (int cfg = 0; cfg < 2; cfg++) begin
        stab_count = 8'(n);
        ext_sel_cfg = cfg[0];
        em = main_sel ? 0 : 3;
        run(2'd1, 60);
        chk("R6 int->ext main step", c_main, em);
        chk("R6 int->ext done", c_done, 4);
        chk("R6 source ext", cur_src, 1);
        chk("R6 main_sel set", main_sel, 1);
        run(2'd2, 60);
        chk("R5 settle window", c_css, n + 3);
        chk("R5 done", c_done, n + 4);
        chk("R5 source sub", {cur_src, cpu_sub_sel}, 5);
        run(2'd0, 60);
        chk("R4 main step", c_main, cfg ? 3 : 0);
        chk("R4 cpu step", c_css, cfg ? 4 : 3);
        chk("R4 done", c_done, cfg ? 5 : 4);
        chk("R4 main_sel final", main_sel, cfg ? 0 : 1);
        chk("R4 source int", {cur_src, cpu_sub_sel}, 0);
        if (main_sel) begin
          ext_sel_cfg = 1'b1;
          run(2'd1, 60);
          run(2'd2, 60);
          run(2'd0, 60);
          chk("R4 restore main_sel", main_sel, 0);
        end
        run(2'd2, 60);
        chk("R5 int->sub window", c_css, n + 3);
        run(2'd1, 60);
        chk("R6 sub->ext main", c_main, 3);
        chk("R6 sub->ext cpu clear", c_css, 4);
        chk("R6 sub->ext done", c_done, 5);
        stop_pulse();
        chk("R9 stop honoured", int_stop, 1);
        run(2'd0, 60);
        chk("R3 stop cleared first", c_stop, 1);
        chk("R3 main cleared", c_main, 3);
        chk("R3 done", c_done, 4);
        chk("R3 source int", cur_src, 0);
      end
    end

    stab_count = 8'd10;
    req_valid = 1'b1; req_target = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_target = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 30 && !done; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 busy request ignored", cur_src, 2);
    chk("R7 no second sequence", busy, 0);

    run(2'd1, 60);
    stop_pulse();
    int_osc_ok = 1'b0;
    run(2'd0, 60);
    chk("R8 abort cycle", c_done, TMO + 1);
    chk("R8 err", err, 1);
    chk("R8 selects kept", {main_sel, cpu_sub_sel}, 2);
    chk("R8 source kept", cur_src, 1);
    int_osc_ok = 1'b1;
    run(2'd0, 60);
    chk("R8 err cleared", err, 0);
    chk("R8 recovery", cur_src, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule